// File: doc/BRIEF.md
# Three-Wire Control Register Receiver

This block takes 16-bit control words from a host over three wires: a select line, a serial clock and a data line. While the select line is high, each rising edge of the serial clock shifts one data bit in, least significant bit first. When the select line falls, a complete word is copied into a bank of control outputs. These outputs drive an audio front end: a filter cut-off choice, a record or playback mode with a playback path choice, power enables, a line mute and a five-bit volume code.

The three serial pins are asynchronous to the system clock. Each passes through a two-stage synchroniser before edge detection. After reset, and again each time the standby input is released, the first select window is treated as a throwaway frame. Real data is accepted only from the second window on. Holding the standby input low forces every control output back to its default value.

Top module: `serial_ctl_rx`

## Requirements
- R1: A frame is the data bits sampled on serial clock rising edges while `cs_pin` is high, first bit first. Frame bit n lands as follows: bit 0 is discarded, bit 1 `cut_4k` (1 = 4 kHz), bit 2 `chg_off`, bit 3 `mic_off`, bit 4 `alc_off`, bit 5 `rec_mode` (1 = record), bit 6 `pb_digital`, bit 7 `rec_off`, bit 8 `line_off`, bit 9 `mute_off` (0 = line muted), bit 10 `spk_off`. Bits 11 to 15 form `vol_code` with bit 11 as its LSB (31 = loudest, 0 = mute). All enables are active low (0 = on).
- R2: After reset the outputs hold the default frame 0x0502. That is, `cut_4k`, `line_off` and `spk_off` are 1, every other bit is 0 and `vol_code` is 0.
- R3: After reset, and after each release of standby, the first select window is discarded whatever it contains. The second window and later ones commit.
- R4: A window that ends with a bit count other than 16 (fewer or more) is discarded, and all outputs keep their values.
- R5: While `standby_n` is low, the outputs are forced to the defaults from the next clock edge on. Serial traffic during standby has no effect, and the first window after release is discarded again.
- R6: Outputs change only when a window closes. The change happens on the third system clock edge after `cs_pin` falls. Serial clock edges while `cs_pin` is low have no effect.
- R7: `filter_sel` is 2'b10 whenever record mode is selected, whatever bit 6 holds. In playback it is 2'b01 for the digital path and 2'b00 for the analog path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_n | input | 1 | Low forces defaults and re-arms the throwaway frame |
| cs_pin | input | 1 | Serial select, high during a frame |
| sclk_pin | input | 1 | Serial clock, data sampled on rising edge |
| sdata_pin | input | 1 | Serial data, first bit first |
| cut_4k | output | 1 | Filter cut-off, 1 = 4 kHz, 0 = 11 kHz |
| chg_off | output | 1 | Reference charge circuit off (active-low enable) |
| mic_off | output | 1 | Mic amplifier off |
| alc_off | output | 1 | Level-control amplifier off |
| rec_mode | output | 1 | 1 = record, 0 = playback |
| pb_digital | output | 1 | Playback path choice, 1 = digital |
| rec_off | output | 1 | Record block off |
| line_off | output | 1 | Line output off |
| mute_off | output | 1 | Line mute released (0 = muted) |
| spk_off | output | 1 | Speaker amplifier off |
| vol_code | output | 5 | Volume code, 0 = mute, 31 = maximum |
| filter_sel | output | 2 | Decoded filter path: 00 analog, 01 digital, 10 record |

## Verification
Full 16-bit frames carry distinct bit patterns: all ones, alternating bits, single set bits at either end, and maximum volume. These patterns show that each field lands at its own position and that the bit order is not reversed. Frames of 15 and 17 bits, an empty select pulse and serial clock toggling with select low are sent to separate the bit-count check from edge gating. A standby pulse with traffic during standby, followed by a throwaway frame and a real frame, shows that the throwaway rule is re-armed. The four combinations of the mode and path bits show that the path bit is ignored in record mode.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

    localparam int FRAME_BITS = 16;
    localparam int PAYLOAD_W  = FRAME_BITS - 1;
    localparam int VOL_W      = 5;

    typedef struct packed {
        logic [VOL_W-1:0] vol;
        logic             spk_off;
        logic             mute_off;
        logic             line_off;
        logic             rec_off;
        logic             pb_dig;
        logic             rec_sel;
        logic             alc_off;
        logic             mic_off;
        logic             chg_off;
        logic             cut_4k;
    } ctl_word_t;

    localparam ctl_word_t CTL_DEFAULT = '{
        vol:      '0,
        spk_off:  1'b1,
        mute_off: 1'b0,
        line_off: 1'b1,
        rec_off:  1'b0,
        pb_dig:   1'b0,
        rec_sel:  1'b0,
        alc_off:  1'b0,
        mic_off:  1'b0,
        chg_off:  1'b0,
        cut_4k:   1'b1
    };

    typedef enum logic [1:0] {
        PATH_PB_ANALOG  = 2'b00,
        PATH_PB_DIGITAL = 2'b01,
        PATH_RECORD     = 2'b10
    } path_t;

    function automatic path_t path_of(ctl_word_t w);
        if (w.rec_sel)
            return PATH_RECORD;
        else if (w.pb_dig)
            return PATH_PB_DIGITAL;
        else
            return PATH_PB_ANALOG;
    endfunction

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst)
                    chain <= '0;
                else
                    chain <= {chain[STAGES-2:0], d[i]};
            end
            assign q[i] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sctl_shifter.sv
module sctl_shifter #(
    parameter int FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic                  cs,
    input  logic                  sclk,
    input  logic                  sdata,
    output logic                  frame_end,
    output logic                  frame_ok,
    output logic [FRAME_BITS-2:0] payload
);

    localparam int CNT_W = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

    logic             cs_q;
    logic             sclk_q;
    logic [CNT_W-1:0] cnt;

    // The shift register is one bit shorter than a frame: the leading
    // throwaway bit falls off the end after the last shift.
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cs_q    <= 1'b0;
            sclk_q  <= 1'b0;
            cnt     <= '0;
            payload <= '0;
        end else begin
            cs_q   <= cs;
            sclk_q <= sclk;
            if (!cs) begin
                cnt <= '0;
            end else if (sclk && !sclk_q) begin
                payload <= {sdata, payload[FRAME_BITS-2:1]};
                if (cnt != CNT_OVER)
                    cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assign frame_end = cs_q && !cs;
    assign frame_ok  = (cnt == CNT_FULL);

    // R6: select held low keeps the bit counter empty
    assert_idle_count_R6: assert property (@(posedge clk) disable iff (rst || clear)
        (!cs) |=> (cnt == '0));

endmodule

// File: rtl/sctl_bank.sv
module sctl_bank
    import sctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      standby_n,
    input  logic      frame_end,
    input  logic      frame_ok,
    input  ctl_word_t payload,
    output ctl_word_t ctl
);

    logic dummy_pend;

    always_ff @(posedge clk) begin
        if (rst || !standby_n) begin
            ctl        <= CTL_DEFAULT;
            dummy_pend <= 1'b1;
        end else if (frame_end) begin
            if (dummy_pend)
                dummy_pend <= 1'b0;
            else if (frame_ok)
                ctl <= payload;
        end
    end

    assert_standby_default_R5: assert property (@(posedge clk) disable iff (rst)
        (!standby_n) |=> (ctl == CTL_DEFAULT && dummy_pend));

    assert_dummy_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (standby_n && frame_end && dummy_pend) |=> ($stable(ctl) && !dummy_pend));

    assert_bad_count_R4: assert property (@(posedge clk) disable iff (rst)
        (standby_n && frame_end && !frame_ok) |=> $stable(ctl));

    assert_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (standby_n && !frame_end) |=> $stable(ctl));

    assert_commit_R1: assert property (@(posedge clk) disable iff (rst)
        (standby_n && frame_end && frame_ok && !dummy_pend) |=> (ctl == $past(payload)));

endmodule

// File: rtl/serial_ctl_rx.sv
module serial_ctl_rx
    import sctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             standby_n,
    input  logic             cs_pin,
    input  logic             sclk_pin,
    input  logic             sdata_pin,
    output logic             cut_4k,
    output logic             chg_off,
    output logic             mic_off,
    output logic             alc_off,
    output logic             rec_mode,
    output logic             pb_digital,
    output logic             rec_off,
    output logic             line_off,
    output logic             mute_off,
    output logic             spk_off,
    output logic [VOL_W-1:0] vol_code,
    output logic [1:0]       filter_sel
);

    logic [2:0] pins_s;
    logic       frame_end;
    logic       frame_ok;
    ctl_word_t  payload;
    ctl_word_t  ctl;
    path_t      path;

    sctl_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_pin, sclk_pin, sdata_pin}),
        .q   (pins_s)
    );

    sctl_shifter #(
        .FRAME_BITS (FRAME_BITS)
    ) i_shift (
        .clk       (clk),
        .rst       (rst),
        .clear     (!standby_n),
        .cs        (pins_s[2]),
        .sclk      (pins_s[1]),
        .sdata     (pins_s[0]),
        .frame_end (frame_end),
        .frame_ok  (frame_ok),
        .payload   (payload)
    );

    sctl_bank i_bank (
        .clk       (clk),
        .rst       (rst),
        .standby_n (standby_n),
        .frame_end (frame_end),
        .frame_ok  (frame_ok),
        .payload   (payload),
        .ctl       (ctl)
    );

    assign path       = path_of(ctl);
    assign cut_4k     = ctl.cut_4k;
    assign chg_off    = ctl.chg_off;
    assign mic_off    = ctl.mic_off;
    assign alc_off    = ctl.alc_off;
    assign rec_mode   = ctl.rec_sel;
    assign pb_digital = ctl.pb_dig;
    assign rec_off    = ctl.rec_off;
    assign line_off   = ctl.line_off;
    assign mute_off   = ctl.mute_off;
    assign spk_off    = ctl.spk_off;
    assign vol_code   = ctl.vol;
    assign filter_sel = path;

    assert_record_path_R7: assert property (@(posedge clk) disable iff (rst)
        rec_mode |-> (filter_sel == 2'b10));

endmodule

// File: tb/test_serial_ctl_rx.sv
module test_serial_ctl_rx;

    localparam int HALF = 6;
    localparam logic [15:0] DEF = 16'h0502;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       standby_n = 1'b1;
    logic       cs_pin = 1'b0;
    logic       sclk_pin = 1'b0;
    logic       sdata_pin = 1'b0;
    logic       cut_4k, chg_off, mic_off, alc_off, rec_mode, pb_digital;
    logic       rec_off, line_off, mute_off, spk_off;
    logic [4:0] vol_code;
    logic [1:0] filter_sel;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R2";
    logic  [15:0] m_exp = DEF;
    logic  m_dummy = 1'b1;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    serial_ctl_rx i_serial_ctl_rx (
        .clk(clk), .rst(rst), .standby_n(standby_n),
        .cs_pin(cs_pin), .sclk_pin(sclk_pin), .sdata_pin(sdata_pin),
        .cut_4k(cut_4k), .chg_off(chg_off), .mic_off(mic_off), .alc_off(alc_off),
        .rec_mode(rec_mode), .pb_digital(pb_digital), .rec_off(rec_off),
        .line_off(line_off), .mute_off(mute_off), .spk_off(spk_off),
        .vol_code(vol_code), .filter_sel(filter_sel)
    );

    function automatic logic [1:0] exp_path(logic [15:0] w);
        if (w[5]) return 2'b10;
        if (w[6]) return 2'b01;
        return 2'b00;
    endfunction

    // Compare on every clock against the behavioural model
    always @(negedge clk) begin
        logic [16:0] got;
        logic [16:0] want;
        if (!rst && !done) begin
            got  = {vol_code, spk_off, mute_off, line_off, rec_off, pb_digital,
                    rec_mode, alc_off, mic_off, chg_off, cut_4k, filter_sel};
            want = {m_exp[15:1], exp_path(m_exp)};
            n_chk++;
            if (got !== want) begin
                n_fail++;
                $display("FAIL %s: outputs %h expected %h", cur_req, got, want);
            end
        end
    end

    task automatic send_frame(input logic [31:0] bits, input int n);
        @(negedge clk) cs_pin = 1'b1;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            sdata_pin = bits[i];
            repeat (HALF) @(negedge clk);
            sclk_pin = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk_pin = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_pin = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        if (standby_n) begin
            if (m_dummy)
                m_dummy = 1'b0;
            else if (n == 16)
                m_exp = bits[15:0];
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic idle_clocks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sdata_pin = ~sdata_pin;
            repeat (HALF) @(negedge clk);
            sclk_pin = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk_pin = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        cur_req = "R2";
        repeat (10) @(negedge clk);

        cur_req = "R3";
        send_frame(32'h0000_FFFF, 16);
        send_frame(32'h0000_A5C3, 16);

        cur_req = "R1";
        send_frame(32'h0000_5556, 16);
        send_frame(32'h0000_8000, 16);
        send_frame(32'h0000_0002, 16);
        send_frame(32'h0000_F800, 16);
        send_frame(32'h0000_3C6A, 16);

        cur_req = "R4";
        send_frame(32'h0000_1234, 15);
        send_frame(32'h0001_0FF0, 17);
        send_frame(32'h0, 0);

        cur_req = "R6";
        idle_clocks(20);
        send_frame(32'h0000_4A1E, 16);
        idle_clocks(5);

        cur_req = "R7";
        send_frame(32'h0000_0060, 16);
        send_frame(32'h0000_0020, 16);
        send_frame(32'h0000_0040, 16);
        send_frame(32'h0000_0000, 16);

        cur_req = "R5";
        send_frame(32'h0000_FFFE, 16);
        @(negedge clk) standby_n = 1'b0;
        @(posedge clk);
        #1;
        m_exp = DEF;
        m_dummy = 1'b1;
        send_frame(32'h0000_7777, 16);
        @(negedge clk) standby_n = 1'b1;
        repeat (4) @(negedge clk);
        send_frame(32'h0000_9999, 16);
        send_frame(32'h0000_C3A4, 16);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL %s: watchdog expired, got timeout expected completion", cur_req);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule